// File: doc/BRIEF.md
# Span-Scaled PWM Duty Output

This block turns each new burst-length count from a capacitance front end into an 8-bit value. The value is placed between two counts learned during calibration. One endpoint count is taken at the minimum-capacitance end and maps to 0. The other is taken at the maximum-capacitance end and maps to 255. A larger capacitance gives a shorter burst, so the value rises as the count falls from the minimum-end count toward the maximum-end count.

The value is produced by a sequential shift-subtract divider. It then drives a fixed-period PWM output, whose duty is the high time over the period. An external RC filter can turn that output into a voltage.

While the calibration flag is high, the output stays at the value it had before calibration began. New values are applied only at a PWM period boundary, so the output never shows a runt pulse.

Top module: `span_pwm_out`

## Requirements
- R1: After reset the output is low and stays low, which is a duty of 0, until a count is converted.
- R2: For a count between the endpoints, the duty is floor(255 × |cmin − count| / |cmin − cmax|). Here cmin is the minimum-capacitance endpoint count, cmax is the maximum-capacitance endpoint count, and all counts are unsigned 16-bit values. A count equal to cmin gives 0 and a count equal to cmax gives 255.
- R3: A count beyond cmin, on the side away from cmax, gives 0. A count beyond cmax, on the side away from cmin, gives 255.
- R4: The formula of R2 holds for either endpoint ordering, whether cmin > cmax or cmin < cmax.
- R5: When cmin equals cmax, every count gives a duty of 0.
- R6: The PWM period is PERIOD_CLKS clock cycles. Each period is high for its first ceil(duty × PERIOD_CLKS / 255) cycles and low for the rest. A duty of 0 is never high and a duty of 255 is always high.
- R7: A new duty takes effect only at a period boundary. After a change, the first full low run and the first full high run both match the new duty.
- R8: While cal_busy_i is high, the output keeps its duty. Strobes are ignored, and a conversion that completes during calibration is discarded. Once the flag falls, the next strobe updates the output.
- R9: A strobe that arrives while a conversion is in progress is ignored. A conversion completes within CNT_W + 10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_vld_i | input | 1 | One-cycle strobe: a new burst count is present |
| burst_cnt_i | input | CNT_W | Burst-length count |
| ref_min_cnt_i | input | CNT_W | Count learned at the minimum-capacitance end (maps to 0) |
| ref_max_cnt_i | input | CNT_W | Count learned at the maximum-capacitance end (maps to 255) |
| cal_busy_i | input | 1 | Calibration in progress; freezes the output |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions watch several properties on every cycle:
- a quotient that never exceeds 8 bits;
- a held duty that never changes while calibration is running;
- an active duty that changes only after a period's last cycle;
- a phase counter that wraps;
- a pin that is solid low at duty 0 and solid high at duty 255.

The numeric mapping cannot be seen by a property; only the bench's sweeps and corner-case counts can show it. The sweeps cover both endpoint orderings, clamping, equal endpoints and full-range 16-bit counts. The same holds for dropped strobes and discarded results, and for the exact run lengths across a duty change.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_RUN  = 2'd1,
    CV_DONE = 2'd2
  } cv_state_t;
endpackage

// File: rtl/span_ratio_div.sv
module span_ratio_div
  import spwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmin_i,
  input  logic [CNT_W-1:0]  cmax_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int FULL   = (1 << DUTY_W) - 1;
  localparam int NUM_W  = CNT_W + DUTY_W;
  localparam int SW     = CNT_W + 2;
  localparam int ITER_W = $clog2(NUM_W + 1);

  cv_state_t          st_q;
  logic [NUM_W-1:0]   num_q;
  logic [NUM_W-1:0]   quo_q;
  logic [CNT_W-1:0]   den_q;
  logic [CNT_W-1:0]   rem_q;
  logic [ITER_W-1:0]  iter_q;

  // Signed span arithmetic, folded so the span is always positive
  logic signed [SW-1:0] n_s, d_s;
  logic                 span_zero, side_low, side_high;
  logic [NUM_W-1:0]     num_start;

  function automatic logic [NUM_W-1:0] scale_full(input logic [CNT_W-1:0] v);
    return NUM_W'(FULL) * NUM_W'(v);
  endfunction

  always_comb begin
    n_s = $signed({2'b00, cmin_i}) - $signed({2'b00, cnt_i});
    d_s = $signed({2'b00, cmin_i}) - $signed({2'b00, cmax_i});
    if (d_s < 0) begin
      n_s = -n_s;
      d_s = -d_s;
    end
    span_zero = (d_s == '0);
    side_low  = (n_s <= 0);
    side_high = (n_s >= d_s);
    num_start = scale_full(n_s[CNT_W-1:0]);
  end

  // One shift-subtract step
  logic [CNT_W:0] rem_ext, rem_sub;
  logic           step_ge;
  always_comb begin
    rem_ext = {rem_q, num_q[NUM_W-1]};
    step_ge = (rem_ext >= {1'b0, den_q});
    rem_sub = step_ge ? (rem_ext - {1'b0, den_q}) : rem_ext;
  end

  wire accept   = start_i && (st_q == CV_IDLE);
  wire last_it  = (st_q == CV_RUN) && (iter_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CV_IDLE;
      num_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      iter_q <= '0;
    end else begin
      unique case (st_q)
        CV_IDLE: begin
          if (accept) begin
            rem_q  <= '0;
            iter_q <= ITER_W'(NUM_W - 1);
            num_q  <= num_start;
            den_q  <= d_s[CNT_W-1:0];
            if (span_zero || side_low) begin
              quo_q <= '0;
              st_q  <= CV_DONE;
            end else if (side_high) begin
              quo_q <= NUM_W'(FULL);
              st_q  <= CV_DONE;
            end else begin
              quo_q <= '0;
              st_q  <= CV_RUN;
            end
          end
        end
        CV_RUN: begin
          rem_q  <= rem_sub[CNT_W-1:0];
          num_q  <= {num_q[NUM_W-2:0], 1'b0};
          quo_q  <= {quo_q[NUM_W-2:0], step_ge};
          iter_q <= iter_q - 1'b1;
          if (last_it) st_q <= CV_DONE;
        end
        default: st_q <= CV_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != CV_IDLE);
  assign done_o = (st_q == CV_DONE);
  assign duty_o = quo_q[DUTY_W-1:0];

  // R2/R3: the scaled ratio never needs more than DUTY_W bits
  a_r2_quot_fits: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (quo_q[NUM_W-1:DUTY_W] == '0));
  // R9: a conversion is never entered from any state but idle
  a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CV_RUN) && !$past(st_q == CV_RUN) |-> $past(st_q == CV_IDLE));
endmodule

// File: rtl/duty_hold.sv
module duty_hold #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld_i,
  input  logic [DUTY_W-1:0] res_duty_i,
  input  logic              cal_busy_i,
  input  logic              period_end_i,
  output logic [DUTY_W-1:0] duty_act_o
);
  logic [DUTY_W-1:0] held_q;
  logic [DUTY_W-1:0] act_q;

  wire commit = res_vld_i && !cal_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      act_q  <= '0;
    end else begin
      if (commit)       held_q <= res_duty_i;
      if (period_end_i) act_q  <= held_q;
    end
  end

  assign duty_act_o = act_q;

  // R8: nothing is committed while calibration runs
  a_r8_freeze_during_cal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cal_busy_i) |-> $stable(held_q));
  // R7: the active duty moves only right after a period's last cycle
  a_r7_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(period_end_i));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int PERIOD_CLKS = 1250,
  parameter int DUTY_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              period_end_o,
  output logic              pwm_o
);
  localparam int FULL   = (1 << DUTY_W) - 1;
  localparam int PH_W   = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
  localparam int PROD_W = $clog2(PERIOD_CLKS + 1) + DUTY_W;

  logic [PH_W-1:0] phase_q;
  logic            pwm_q;

  // High while phase * FULL < duty * PERIOD, i.e. ceil(duty*P/FULL) cycles
  function automatic logic high_at(input logic [PH_W-1:0] ph,
                                   input logic [DUTY_W-1:0] dv);
    logic [PROD_W-1:0] lhs, rhs;
    lhs = PROD_W'(ph) * PROD_W'(FULL);
    rhs = PROD_W'(dv) * PROD_W'(PERIOD_CLKS);
    return lhs < rhs;
  endfunction

  assign period_end_o = (phase_q == PH_W'(PERIOD_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      phase_q <= period_end_o ? '0 : phase_q + 1'b1;
      pwm_q   <= high_at(phase_q, duty_i);
    end
  end

  assign pwm_o = pwm_q;

  a_r6_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> (phase_q == '0));
  a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |=> !pwm_o);
  a_r6_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == DUTY_W'(FULL)) |=> pwm_o);
endmodule

// File: rtl/span_pwm_out.sv
module span_pwm_out #(
  parameter int CNT_W       = 16,
  parameter int DUTY_W      = 8,
  parameter int PERIOD_CLKS = 1250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_vld_i,
  input  logic [CNT_W-1:0] burst_cnt_i,
  input  logic [CNT_W-1:0] ref_min_cnt_i,
  input  logic [CNT_W-1:0] ref_max_cnt_i,
  input  logic             cal_busy_i,
  output logic             pwm_o
);
  logic              div_busy, div_done, period_end;
  logic [DUTY_W-1:0] div_duty, duty_act;

  // R8/R9: strobes are taken only when idle and not calibrating
  wire conv_start = burst_vld_i && !cal_busy_i && !div_busy;

  span_ratio_div #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(conv_start),
    .cnt_i  (burst_cnt_i),
    .cmin_i (ref_min_cnt_i),
    .cmax_i (ref_max_cnt_i),
    .busy_o (div_busy),
    .done_o (div_done),
    .duty_o (div_duty)
  );

  duty_hold #(.DUTY_W(DUTY_W)) hold_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_vld_i   (div_done),
    .res_duty_i  (div_duty),
    .cal_busy_i  (cal_busy_i),
    .period_end_i(period_end),
    .duty_act_o  (duty_act)
  );

  pwm_gen #(.PERIOD_CLKS(PERIOD_CLKS), .DUTY_W(DUTY_W)) gen_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_i      (duty_act),
    .period_end_o(period_end),
    .pwm_o       (pwm_o)
  );

  // R9: a conversion runs only after a strobe seen outside calibration
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> div_busy);
endmodule

// File: tb/span_pwm_out_tb_top.sv
module span_pwm_out_tb_top;
  localparam int CNT_W = 16;
  localparam int P     = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_vld = 1'b0;
  logic [CNT_W-1:0] burst_cnt = '0, cmin = '0, cmax = '0;
  logic cal_busy = 1'b0;
  logic pwm;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  span_pwm_out #(.CNT_W(CNT_W), .DUTY_W(8), .PERIOD_CLKS(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_vld_i(burst_vld), .burst_cnt_i(burst_cnt),
    .ref_min_cnt_i(cmin), .ref_max_cnt_i(cmax), .cal_busy_i(cal_busy), .pwm_o(pwm)
  );

  function automatic int exp_duty(input longint lo, input longint hi, input longint c);
    longint n, d;
    n = lo - c;
    d = lo - hi;
    if (d == 0) return 0;
    if (d < 0) begin n = -n; d = -d; end
    if (n <= 0) return 0;
    if (n >= d) return 255;
    return int'((255 * n) / d);
  endfunction

  function automatic int exp_high(input int duty);
    return (duty * P + 254) / 255;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic strobe(input int c);
    @(negedge clk);
    burst_cnt = CNT_W'(c);
    burst_vld = 1'b1;
    @(negedge clk);
    burst_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (40 + P + 4) @(negedge clk);
  endtask

  task automatic measure(output int h);
    h = 0;
    repeat (P) begin
      @(negedge clk);
      h += int'(pwm);
    end
  endtask

  task automatic run_case(input string req, input int lo, input int hi, input int c);
    int h;
    cmin = CNT_W'(lo);
    cmax = CNT_W'(hi);
    strobe(c);
    settle();
    measure(h);
    check(req, h, exp_high(exp_duty(lo, hi, c)));
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int h, run;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    measure(h);
    check("R1", h, 0);

    // R2 / R6: sweep across a span of exactly 255 counts
    for (int k = 0; k < 256; k += 5) run_case("R2", 1000, 745, 1000 - k);
    run_case("R2", 1000, 745, 745);
    // R2: wider span, non-integer ratios
    for (int c = 5000; c >= 1000; c -= 333) run_case("R2", 5000, 1000, c);
    // R2: full 16-bit range
    run_case("R2", 65535, 0, 1);
    run_case("R2", 65535, 0, 32768);

    // R3: clamping on both sides
    run_case("R3", 1000, 745, 1200);
    run_case("R3", 1000, 745, 100);
    run_case("R3", 1000, 745, 0);

    // R4: reversed endpoint ordering
    run_case("R4", 300, 800, 550);
    run_case("R4", 300, 800, 200);
    run_case("R4", 300, 800, 900);
    run_case("R4", 300, 800, 700);

    // R5: equal endpoints, after a nonzero duty
    run_case("R5", 1000, 745, 800);
    run_case("R5", 500, 500, 500);
    run_case("R5", 500, 500, 10);

    // R6: extremes
    run_case("R6", 1000, 745, 745);
    run_case("R6", 1000, 745, 1000);

    // R7: change from 255 to 100 gives clean runs
    run_case("R7", 1000, 745, 745);
    strobe(900);
    run = 0;
    for (int i = 0; i < 4 * P && pwm; i++) @(negedge clk);
    for (int i = 0; i < 4 * P && !pwm; i++) begin run++; @(negedge clk); end
    check("R7", run, P - exp_high(100));
    run = 0;
    for (int i = 0; i < 4 * P && pwm; i++) begin run++; @(negedge clk); end
    check("R7", run, exp_high(100));

    // R8: strobe during calibration is ignored
    run_case("R8", 1000, 745, 950);
    @(negedge clk); cal_busy = 1'b1;
    strobe(800);
    settle();
    measure(h);
    check("R8", h, exp_high(50));
    @(negedge clk); cal_busy = 1'b0;
    settle();
    measure(h);
    check("R8", h, exp_high(50));
    // R8: result finishing during calibration is discarded
    strobe(800);
    repeat (2) @(negedge clk);
    cal_busy = 1'b1;
    settle();
    @(negedge clk); cal_busy = 1'b0;
    settle();
    measure(h);
    check("R8", h, exp_high(50));
    run_case("R8", 1000, 745, 800);

    // R9: second strobe during conversion is dropped
    @(negedge clk);
    burst_cnt = CNT_W'(990); burst_vld = 1'b1;
    @(negedge clk);
    burst_cnt = CNT_W'(910);
    @(negedge clk);
    burst_vld = 1'b0;
    settle();
    measure(h);
    check("R9", h, exp_high(10));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule